// File: doc/BRIEF.md
# Dual-Mode PCI I/O Window Remapper

This block sits between a processor-side I/O window and a PCI I/O address space. Each accepted processor access carries a window offset, a byte count and, for writes, data. The block folds that offset into a compact I/O address, adds a fixed bus base, and issues a single downstream strobe one cycle later. The downstream strobe carries the address, byte-lane enables and lane-aligned write data. One external select line chooses how the offset is folded. With the line low, the offset is cut down to a linear 64 KB space. With the line high, the window is treated as 4 KB pages, each of which holds only its first 32 bytes of I/O space. The page number is moved down so that it sits directly above those 32 byte offsets.

Only byte counts of 1, 2 and 4 are served, and data is little-endian, with lane 0 holding the lowest address. An access with any other byte count gets an error response and causes no downstream activity. A read holds off further requests until its downstream data returns. The block then hands that data back, trimmed to the requested width.

Top module: `pio_window_remap`

## Requirements
- R1: While reset is held and on the first cycle after it, `dnStb` and `rspValid` are 0 and `reqReady` is 1.
- R2: With the select line at 0 when an access is accepted, the forwarded address is the base plus the offset ANDed with 0xFFFF.
- R3: With the select line at 1 when an access is accepted, the forwarded address is the base plus (offset AND 0x1F) OR ((offset AND 0x7FF000) shifted right by 7). Offset bits 22..12 land at bits 15..5 and bits 4..0 are kept.
- R4: Every forwarded address lies in [base, base + 0x10000), with base = 0x80000000 by default.
- R5: The select line is sampled in the accepting cycle only. Changing it afterwards does not alter that access.
- R6: A legal access drives `dnStb` high in the cycle after acceptance. `dnBe` is 0001, 0011 or 1111 for byte counts 1, 2 or 4. `dnWData` carries the write data in the enabled low lanes and zero elsewhere. `dnWe` copies `reqWrite`.
- R7: A byte count other than 1, 2 or 4 produces `rspValid` and `rspErr` high in the cycle after acceptance, with `rspData` zero and no `dnStb`.
- R8: One cycle after `dnRdValid` returns the data of an outstanding read, `rspValid` is 1, `rspErr` is 0 and `rspData` is `dnRData` with the lanes above the byte count cleared.
- R9: From the cycle after a read is accepted until its data returns, `reqReady` is 0 and any request presented is ignored (no `dnStb`).
- R10: Unaligned offsets are forwarded unchanged in their low bits. The byte count sets only the lane enables and is not blocked by alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | 0 = linear 64 KB fold, 1 = 32-bytes-per-page fold |
| reqValid | input | 1 | Processor access present |
| reqReady | output | 1 | Block can accept an access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 23 | Offset inside the 8 MB window |
| reqSize | input | 3 | Byte count (1, 2, 4 legal) |
| reqWData | input | 32 | Write data, lane 0 = lowest byte |
| rspValid | output | 1 | Response (read data or error) |
| rspErr | output | 1 | Response is an illegal-size error |
| rspData | output | 32 | Read data trimmed to the byte count |
| dnStb | output | 1 | Downstream access strobe |
| dnWe | output | 1 | Downstream write |
| dnAddr | output | 32 | Downstream I/O address |
| dnBe | output | 4 | Downstream byte-lane enables |
| dnWData | output | 32 | Downstream write data |
| dnRdValid | input | 1 | Downstream read data valid |
| dnRData | input | 32 | Downstream read data |

## Verification
The assertions assume that `dnRdValid` is raised only while a read is outstanding and at most once for each read. The stimulus respects this by returning read data exactly once, in the cycle after the read strobe. The assertions also assume that the select line and offsets are stable around the sampling edge. The bench changes inputs only on falling edges and a short time after rising edges.

// File: rtl/pio_remap_pkg.sv
package pio_remap_pkg;

  typedef struct packed {
    logic accept;   // access taken this cycle
    logic legal;    // byte count is 1, 2 or 4
    logic rdDone;   // outstanding read data arrives this cycle
  } remapStrobes_t;

  function automatic logic sizeLegal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

endpackage

// File: rtl/pio_remap_ctrl.sv
module pio_remap_ctrl
  import pio_remap_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [2:0]    reqSize,
  input  logic          dnRdValid,
  output logic          reqReady,
  output remapStrobes_t strobes,
  output logic          dnStb,
  output logic          rspValid,
  output logic          rspErr
);

  logic busy;
  logic accept;
  logic legal;

  assign reqReady = !busy;
  assign accept   = reqValid && reqReady;
  assign legal    = sizeLegal(reqSize);

  assign strobes.accept = accept;
  assign strobes.legal  = legal;
  assign strobes.rdDone = busy && dnRdValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      dnStb    <= 1'b0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      dnStb    <= accept && legal;
      rspErr   <= accept && !legal;
      rspValid <= (accept && !legal) || (busy && dnRdValid);
      if (accept && legal && !reqWrite)
        busy <= 1'b1;
      else if (busy && dnRdValid)
        busy <= 1'b0;
    end
  end

  // R7
  no_err_with_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dnStb && rspErr));

  // R8
  rsp_after_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspErr) |-> $past(dnRdValid));

  // R7
  err_has_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

endmodule

// File: rtl/pio_remap_dpath.sv
module pio_remap_dpath
  import pio_remap_pkg::*;
#(
  parameter int          WIN_AW      = 23,
  parameter int          DN_AW       = 32,
  parameter int          DATA_W      = 32,
  parameter int          PAGE_SHIFT  = 12,
  parameter int          LOW_BITS    = 5,
  parameter int          LINEAR_BITS = 16,
  parameter logic [31:0] IO_BASE     = 32'h8000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  remapStrobes_t       strobes,
  input  logic                modeSel,
  input  logic                reqWrite,
  input  logic [WIN_AW-1:0]   reqAddr,
  input  logic [2:0]          reqSize,
  input  logic [DATA_W-1:0]   reqWData,
  input  logic [DATA_W-1:0]   dnRData,
  input  logic                dnStb,
  output logic                dnWe,
  output logic [DN_AW-1:0]    dnAddr,
  output logic [DATA_W/8-1:0] dnBe,
  output logic [DATA_W-1:0]   dnWData,
  output logic [DATA_W-1:0]   rspData
);

  localparam int LANES  = DATA_W / 8;
  localparam int PAGE_W = WIN_AW - PAGE_SHIFT;
  localparam int FOLD_W = LOW_BITS + PAGE_W;
  localparam int SPAN_W = (FOLD_W > LINEAR_BITS) ? FOLD_W : LINEAR_BITS;

  logic [DN_AW-1:0]  foldedAddr;
  logic [LANES-1:0]  laneEn;
  logic [LANES-1:0]  heldEn;
  logic [DATA_W-1:0] wLanes;
  logic [DATA_W-1:0] rLanes;

  // address fold: linear cut or page compression
  always_comb begin
    foldedAddr = '0;
    if (modeSel) begin
      foldedAddr[LOW_BITS-1:0]       = reqAddr[LOW_BITS-1:0];
      foldedAddr[LOW_BITS +: PAGE_W] = reqAddr[WIN_AW-1:PAGE_SHIFT];
    end else begin
      foldedAddr[LINEAR_BITS-1:0] = reqAddr[LINEAR_BITS-1:0];
    end
  end

  // per-lane enables and data steering
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneEn[g]          = (3'(g) < reqSize);
    assign wLanes[8*g +: 8]   = laneEn[g] ? reqWData[8*g +: 8] : 8'h00;
    assign rLanes[8*g +: 8]   = heldEn[g] ? dnRData[8*g +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dnWe    <= 1'b0;
      dnAddr  <= '0;
      dnBe    <= '0;
      dnWData <= '0;
      heldEn  <= '0;
      rspData <= '0;
    end else begin
      if (strobes.accept && strobes.legal) begin
        dnWe    <= reqWrite;
        dnAddr  <= IO_BASE + foldedAddr;
        dnBe    <= laneEn;
        dnWData <= reqWrite ? wLanes : '0;
        heldEn  <= laneEn;
      end
      if (strobes.accept && !strobes.legal)
        rspData <= '0;
      else if (strobes.rdDone)
        rspData <= rLanes;
    end
  end

  // R4
  addr_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    dnStb |-> ((dnAddr - IO_BASE) < (DN_AW'(1) << SPAN_W)));

  // R6
  be_low_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    dnStb |-> ((dnBe != '0) && ((dnBe & (dnBe + 1'b1)) == '0)));

endmodule

// File: rtl/pio_window_remap.sv
module pio_window_remap
  import pio_remap_pkg::*;
#(
  parameter int          WIN_AW      = 23,
  parameter int          DN_AW       = 32,
  parameter int          DATA_W      = 32,
  parameter int          PAGE_SHIFT  = 12,
  parameter int          LOW_BITS    = 5,
  parameter int          LINEAR_BITS = 16,
  parameter logic [31:0] IO_BASE     = 32'h8000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeSel,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [WIN_AW-1:0]   reqAddr,
  input  logic [2:0]          reqSize,
  input  logic [DATA_W-1:0]   reqWData,
  output logic                rspValid,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rspData,
  output logic                dnStb,
  output logic                dnWe,
  output logic [DN_AW-1:0]    dnAddr,
  output logic [DATA_W/8-1:0] dnBe,
  output logic [DATA_W-1:0]   dnWData,
  input  logic                dnRdValid,
  input  logic [DATA_W-1:0]   dnRData
);

  remapStrobes_t strobes;

  pio_remap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqSize   (reqSize),
    .dnRdValid (dnRdValid),
    .reqReady  (reqReady),
    .strobes   (strobes),
    .dnStb     (dnStb),
    .rspValid  (rspValid),
    .rspErr    (rspErr)
  );

  pio_remap_dpath #(
    .WIN_AW      (WIN_AW),
    .DN_AW       (DN_AW),
    .DATA_W      (DATA_W),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .LOW_BITS    (LOW_BITS),
    .LINEAR_BITS (LINEAR_BITS),
    .IO_BASE     (IO_BASE)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .modeSel  (modeSel),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWData (reqWData),
    .dnRData  (dnRData),
    .dnStb    (dnStb),
    .dnWe     (dnWe),
    .dnAddr   (dnAddr),
    .dnBe     (dnBe),
    .dnWData  (dnWData),
    .rspData  (rspData)
  );

  // R9
  read_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnStb && !dnWe) |-> !reqReady);

endmodule

// File: tb/pio_window_remap_tb_top.sv
module pio_window_remap_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        modeSel, reqValid, reqReady, reqWrite;
  logic [22:0] reqAddr;
  logic [2:0]  reqSize;
  logic [31:0] reqWData;
  logic        rspValid, rspErr;
  logic [31:0] rspData;
  logic        dnStb, dnWe;
  logic [31:0] dnAddr;
  logic [3:0]  dnBe;
  logic [31:0] dnWData;
  logic        dnRdValid;
  logic [31:0] dnRData;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pio_window_remap dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .reqValid(reqValid),
    .reqReady(reqReady), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWData(reqWData), .rspValid(rspValid),
    .rspErr(rspErr), .rspData(rspData), .dnStb(dnStb), .dnWe(dnWe),
    .dnAddr(dnAddr), .dnBe(dnBe), .dnWData(dnWData),
    .dnRdValid(dnRdValid), .dnRData(dnRData)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint refAddr(input longint a, input bit m);
    longint r;
    if (m) r = (a & 'h1F) | ((a & 'h7FF000) / 128);
    else   r = a % 65536;
    return 'h8000_0000 + r;
  endfunction

  function automatic longint refMask(input int sz, input longint d);
    if (sz == 1) return d % 256;
    if (sz == 2) return d % 65536;
    return d;
  endfunction

  function automatic longint refBe(input int sz);
    return (sz == 1) ? 1 : (sz == 2) ? 3 : 15;
  endfunction

  task automatic access(input bit wr, input int a, input int sz, input bit md,
                        input longint wd, input longint rd, input bit flip);
    bit legal = (sz == 1) || (sz == 2) || (sz == 4);
    @(negedge clk);
    chk(reqReady == 1'b1, "R9 ready before access", reqReady, 1);
    reqValid = 1; reqWrite = wr; reqAddr = 23'(a); reqSize = 3'(sz);
    modeSel = md; reqWData = 32'(wd);
    @(posedge clk); #1;
    reqValid = 0;
    if (flip) modeSel = ~md;
    @(negedge clk);
    if (legal) begin
      chk(dnStb == 1'b1, "R6 strobe", dnStb, 1);
      chk(dnAddr == 32'(refAddr(a, md)), md ? "R3 folded addr" : "R2 linear addr",
          dnAddr, refAddr(a, md));
      chk(dnBe == 4'(refBe(sz)), "R6 byte enables", dnBe, refBe(sz));
      chk(dnWe == wr, "R6 write flag", dnWe, wr);
      if (wr) chk(dnWData == 32'(refMask(sz, wd)), "R6 write lanes", dnWData, refMask(sz, wd));
      chk(rspValid == 1'b0, "R6 no response", rspValid, 0);
      if (!wr) begin
        chk(reqReady == 1'b0, "R9 ready low while read open", reqReady, 0);
        dnRdValid = 1; dnRData = 32'(rd);
        reqValid = 1; reqWrite = 1; reqSize = 3'd4; reqAddr = 23'h1234;
        @(posedge clk); #1;
        dnRdValid = 0; reqValid = 0;
        @(negedge clk);
        chk(rspValid == 1'b1 && rspErr == 1'b0, "R8 read response", {rspValid, rspErr}, 2);
        chk(rspData == 32'(refMask(sz, rd)), "R8 read data", rspData, refMask(sz, rd));
        chk(dnStb == 1'b0, "R9 request ignored while busy", dnStb, 0);
      end
    end else begin
      chk(dnStb == 1'b0, "R7 no strobe", dnStb, 0);
      chk(rspValid == 1'b1 && rspErr == 1'b1, "R7 error response", {rspValid, rspErr}, 3);
      chk(rspData == 32'h0, "R7 error data", rspData, 0);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    rstN = 0; modeSel = 0; reqValid = 0; reqWrite = 0; reqAddr = '0;
    reqSize = 3'd1; reqWData = '0; dnRdValid = 0; dnRData = '0;
    repeat (3) @(negedge clk);
    chk(dnStb == 0 && rspValid == 0 && reqReady == 1, "R1 reset state",
        {dnStb, rspValid, reqReady}, 1);
    rstN = 1;
    @(negedge clk);
    chk(dnStb == 0 && rspValid == 0 && reqReady == 1, "R1 after reset",
        {dnStb, rspValid, reqReady}, 1);

    // R2 linear mode, high offset bits dropped
    access(1, 'h7ABCDE, 1, 0, 'h11223344, 0, 0);
    access(1, 'h00CFC,  4, 0, 'hDEADBEEF, 0, 0);
    access(1, 'h40FFFF, 2, 0, 'hCAFEF00D, 0, 0);
    // R3 page-compressed mode
    access(1, 'h003004, 4, 1, 'h01020304, 0, 0);
    access(1, 'h7FF01F, 1, 1, 'h000000A5, 0, 0);
    access(1, 'h000FE0, 2, 1, 'h0000BEEF, 0, 0);
    // R10 unaligned offsets
    access(1, 'h000003, 4, 0, 'h55667788, 0, 0);
    access(1, 'h005017, 2, 1, 'h9999ABCD, 0, 0);
    // R5 mode flips right after acceptance
    access(1, 'h123456, 4, 1, 'h0BADF00D, 0, 1);
    access(1, 'h123456, 4, 0, 'h0BADF00D, 0, 1);
    // R7 illegal sizes
    access(1, 'h000100, 0, 0, 'h1, 0, 0);
    access(0, 'h000100, 3, 1, 'h1, 0, 0);
    access(1, 'h000100, 5, 0, 'h1, 0, 0);
    access(0, 'h000100, 7, 0, 'h1, 0, 0);
    // R8 reads of each width
    access(0, 'h0000F0, 1, 0, 0, 'hA1B2C3D4, 0);
    access(0, 'h0020F1, 2, 1, 0, 'hA1B2C3D4, 0);
    access(0, 'h7FFFFC, 4, 1, 0, 'hA1B2C3D4, 1);
    // sweep
    seed = 32'h1ACE_5EED;
    for (int i = 0; i < 40; i++) begin
      int sizes[4] = '{1, 2, 4, 6};
      seed = seed * 1103515245 + 12345;
      access(seed[3], (seed >>> 4) & 'h7FFFFF, sizes[seed[1:0]], seed[2],
             longint'(unsigned'(seed)), longint'(unsigned'(seed ^ 32'h5A5A5A5A)), seed[9]);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule